// File: doc/BRIEF.md
# Interrupt Enable and Pending Bank

This block keeps the enable and pending state of every source of a 64-source interrupt distributor. Software reaches it through a plain 32-bit register port with a word address, a write strobe, write data and combinational read data. Enable bits and pending bits each have one word view that only sets bits and another that only clears them, so a zero written anywhere leaves state untouched. Both views of a pair return the same current state.

Sources 0 to 15 are software sources: their enable is tied on and they become pending only through a dedicated per-ID trigger input. Sources 16 to 28 are absent. Sources 29 to 31 are plain software-settable sources. Sources 32 to 63 follow 32 hardware lines, each of which can be sensed as an active-high level or as a rising edge, as chosen in a two-bit field per source. An acknowledge path clears the latched pending bit of one ID. The block drives the vector of sources that are both enabled and pending, gated by a global enable bit.

Top module: `irq_bank`

## Requirements
- R1: A 1 written to the set-enable word (0x100 for IDs 0–31, 0x104 for IDs 32–63) sets that enable bit and a 0 leaves it unchanged. A 1 written to the clear-enable word (0x180/0x184) clears it. Both words read back the current enables.
- R2: Enables of IDs 0–15 always read 1. Enables and pending bits of IDs 16–28 always read 0 and ignore writes.
- R3: A 1 written to the set-pending word (0x200/0x204) sets the pending bit, and a 1 written to the clear-pending word (0x280/0x284) clears it, for IDs 29–63. Both words read back current pending. Writes through these words to IDs 0–15 are ignored.
- R4: A high on sgi_set[k] (k in 0–15) during a clock edge makes ID k pending from that edge on.
- R5: ack_valid high with ack_id = n during an edge clears the latched pending bit of ID n. A level source whose line is still high stays pending.
- R6: A hardware source in rising-edge mode becomes pending on the second clock edge after its line rises, and stays pending after the line falls until it is cleared.
- R7: A hardware source in level mode reads pending one edge after its line goes high and stops one edge after it goes low, unless software has set its pending bit.
- R8: irq_out[n] is 1 exactly when ID n is enabled and pending and control bit 0 (global enable, word 0x000) is 1. When the global enable is 0, irq_out is all zero.
- R9: Configuration words 0xC00–0xC0C hold two bits per ID: ID n uses bits [2(n mod 16)+1 : 2(n mod 16)] of word 0xC00 + 4·(n div 16). The upper bit set means rising-edge mode. In 0xC00 only the lower bit of each pair is writable (reads 0x55555555 after writing all ones). 0xC04 always reads 0. 0xC08 and 0xC0C are fully writable. All reset to 0.
- R10: The type word 0x004 reads 0x00000001 (line count code 1, one CPU) and ignores writes. The control word reads only bit 0. Unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 10 | Word address (byte address bits 11:2) |
| reg_wr | input | 1 | Write strobe, one word per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| hw_irq | input | 32 | Hardware lines for IDs 32–63 |
| sgi_set | input | 16 | Per-ID software trigger for IDs 0–15 |
| ack_valid | input | 1 | Acknowledge clear strobe |
| ack_id | input | 6 | ID whose pending bit is cleared |
| irq_out | output | 64 | Enabled and pending sources, globally gated |

## Verification
The properties assume that a register write and an acknowledge for the same bit do not arrive in the same cycle as a competing set, and that hardware lines are already synchronous to clk. The stimulus keeps to this: register traffic, trigger pulses and acknowledges are each driven in cycles of their own, and the lines change only on the falling clock edge. Edge and level behaviour is checked against a timing count of the sampling and pending registers.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  localparam int REG_W  = 32;
  localparam int ADDR_W = 12;
  localparam int RGN_W  = 5;
  localparam int WIDX_W = 5;

  typedef enum logic [RGN_W-1:0] {
    RGN_CTRL   = 5'd0,
    RGN_SET_EN = 5'd2,
    RGN_CLR_EN = 5'd3,
    RGN_SET_PD = 5'd4,
    RGN_CLR_PD = 5'd5,
    RGN_CFG    = 5'd24
  } region_e;

  // enable tied to one for software sources
  function automatic logic f_en_fixed(int id, int n_sgi);
    return id < n_sgi;
  endfunction

  // bit writable by software through set/clear views
  function automatic logic f_sw_writable(int id, int priv_base);
    return id >= priv_base;
  endfunction

  // writable bits of the two-bit configuration field
  function automatic logic [1:0] f_cfg_mask(int id, int n_sgi, int hw_base);
    if (id < n_sgi)       return 2'b01;
    else if (id < hw_base) return 2'b00;
    else                  return 2'b11;
  endfunction

  // identification word: line code in [4:0], cpu count minus one in [7:5]
  function automatic logic [REG_W-1:0] f_type_word(int n_irq);
    logic [4:0] lines;
    lines = 5'((n_irq / REG_W) - 1);
    return {24'd0, 3'd0, lines};
  endfunction

endpackage

// File: rtl/irq_line_sense.sv
module irq_line_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic edge_mode,
  output logic level_hit,
  output logic rise_hit
);
  logic line_q;
  logic line_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q    <= 1'b0;
      line_prev <= 1'b0;
    end else begin
      line_q    <= line_in;
      line_prev <= line_q;
    end
  end

  assign level_hit = line_q & ~edge_mode;
  assign rise_hit  = line_q & ~line_prev & edge_mode;
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux import irq_bank_pkg::*; #(
  parameter int NUM_IRQ = 64,
  parameter logic [REG_W-1:0] TYPE_WORD = 32'h1
) (
  input  logic [RGN_W-1:0]     rgn,
  input  logic [WIDX_W-1:0]    widx,
  input  logic                 dist_en,
  input  logic [NUM_IRQ-1:0]   enable_vec,
  input  logic [NUM_IRQ-1:0]   pend_vec,
  input  logic [2*NUM_IRQ-1:0] cfg_vec,
  output logic [REG_W-1:0]     rdata
);
  localparam int NUM_WORDS = NUM_IRQ / REG_W;
  localparam int CFG_WORDS = 2 * NUM_IRQ / REG_W;

  always_comb begin
    rdata = '0;
    case (rgn)
      RGN_CTRL: begin
        if (widx == 5'd0)      rdata = {{(REG_W-1){1'b0}}, dist_en};
        else if (widx == 5'd1) rdata = TYPE_WORD;
      end
      RGN_SET_EN, RGN_CLR_EN: begin
        for (int w = 0; w < NUM_WORDS; w++)
          if (widx == WIDX_W'(w)) rdata = enable_vec[w*REG_W +: REG_W];
      end
      RGN_SET_PD, RGN_CLR_PD: begin
        for (int w = 0; w < NUM_WORDS; w++)
          if (widx == WIDX_W'(w)) rdata = pend_vec[w*REG_W +: REG_W];
      end
      RGN_CFG: begin
        for (int w = 0; w < CFG_WORDS; w++)
          if (widx == WIDX_W'(w)) rdata = cfg_vec[w*REG_W +: REG_W];
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_bank.sv
module irq_bank import irq_bank_pkg::*; #(
  parameter int NUM_IRQ  = 64,
  parameter int NUM_SGI  = 16,
  parameter int NUM_PRIV = 3,
  parameter int HW_BASE  = 32,
  localparam int NUM_HW  = NUM_IRQ - HW_BASE,
  localparam int ID_W    = $clog2(NUM_IRQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:2] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NUM_HW-1:0] hw_irq,
  input  logic [NUM_SGI-1:0] sgi_set,
  input  logic              ack_valid,
  input  logic [ID_W-1:0]   ack_id,
  output logic [NUM_IRQ-1:0] irq_out
);
  localparam int NUM_WORDS = NUM_IRQ / REG_W;
  localparam int CFG_WORDS = 2 * NUM_IRQ / REG_W;
  localparam int PRIV_BASE = HW_BASE - NUM_PRIV;

  // address split
  logic [RGN_W-1:0]  rgn;
  logic [WIDX_W-1:0] widx;
  assign rgn  = reg_addr[ADDR_W-1:7];
  assign widx = reg_addr[6:2];

  // per-ID constant masks
  logic [NUM_IRQ-1:0]   en_one_m, sw_rw_m, ack_clr;
  logic [2*NUM_IRQ-1:0] cfg_m;
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_id
    assign en_one_m[i]     = f_en_fixed(i, NUM_SGI);
    assign sw_rw_m[i]      = f_sw_writable(i, PRIV_BASE);
    assign cfg_m[2*i +: 2] = f_cfg_mask(i, NUM_SGI, HW_BASE);
    assign ack_clr[i]      = ack_valid && (ack_id == ID_W'(i));
  end

  // write data spread over the ID vector
  logic [NUM_IRQ-1:0] wr_vec;
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_wword
    assign wr_vec[w*REG_W +: REG_W] = (widx == WIDX_W'(w)) ? reg_wdata : '0;
  end

  logic [NUM_IRQ-1:0] wr_set_en, wr_clr_en, wr_set_pd, wr_clr_pd;
  assign wr_set_en = (reg_wr && rgn == RGN_SET_EN) ? (wr_vec & sw_rw_m) : '0;
  assign wr_clr_en = (reg_wr && rgn == RGN_CLR_EN) ? (wr_vec & sw_rw_m) : '0;
  assign wr_set_pd = (reg_wr && rgn == RGN_SET_PD) ? (wr_vec & sw_rw_m) : '0;
  assign wr_clr_pd = (reg_wr && rgn == RGN_CLR_PD) ? (wr_vec & sw_rw_m) : '0;

  logic wr_ctrl;
  assign wr_ctrl = reg_wr && rgn == RGN_CTRL && widx == 5'd0;

  // state
  logic                 dist_en_q;
  logic [NUM_IRQ-1:0]   en_q, pend_q;
  logic [2*NUM_IRQ-1:0] cfg_q;

  // hardware line sensing
  logic [NUM_HW-1:0] lvl_hit, rise_hit;
  for (genvar j = 0; j < NUM_HW; j++) begin : g_line
    irq_line_sense u_sense (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_in   (hw_irq[j]),
      .edge_mode (cfg_q[2*(HW_BASE+j)+1]),
      .level_hit (lvl_hit[j]),
      .rise_hit  (rise_hit[j])
    );
  end

  logic [NUM_IRQ-1:0] hw_lvl_full, hw_rise_full, sgi_full;
  assign hw_lvl_full  = {lvl_hit,  {HW_BASE{1'b0}}};
  assign hw_rise_full = {rise_hit, {HW_BASE{1'b0}}};
  assign sgi_full     = {{(NUM_IRQ-NUM_SGI){1'b0}}, sgi_set};

  // pending update events, named for the checker
  logic [NUM_IRQ-1:0] pend_set, pend_clr;
  assign pend_set = wr_set_pd | sgi_full | hw_rise_full;
  assign pend_clr = wr_clr_pd | ack_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dist_en_q <= 1'b0;
      en_q      <= '0;
      pend_q    <= '0;
      cfg_q     <= '0;
    end else begin
      if (wr_ctrl) dist_en_q <= reg_wdata[0];
      en_q   <= (en_q & ~wr_clr_en) | wr_set_en;
      pend_q <= (pend_q & ~pend_clr) | pend_set;
      for (int w = 0; w < CFG_WORDS; w++)
        if (reg_wr && rgn == RGN_CFG && widx == WIDX_W'(w))
          cfg_q[w*REG_W +: REG_W] <= reg_wdata & cfg_m[w*REG_W +: REG_W];
    end
  end

  logic [NUM_IRQ-1:0] enable_eff, pend_eff;
  assign enable_eff = en_q | en_one_m;
  assign pend_eff   = pend_q | hw_lvl_full;

  assign irq_out = dist_en_q ? (enable_eff & pend_eff) : '0;

  irq_rd_mux #(
    .NUM_IRQ   (NUM_IRQ),
    .TYPE_WORD (f_type_word(NUM_IRQ))
  ) u_rd (
    .rgn        (rgn),
    .widx       (widx),
    .dist_en    (dist_en_q),
    .enable_vec (enable_eff),
    .pend_vec   (pend_eff),
    .cfg_vec    (cfg_q),
    .rdata      (reg_rdata)
  );
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk import irq_bank_pkg::*; #(
  parameter int NUM_IRQ  = 64,
  parameter int NUM_SGI  = 16,
  parameter int PRIV_BASE = 29,
  parameter int HW_BASE  = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:2]     reg_addr,
  input logic                  reg_wr,
  input logic [REG_W-1:0]      reg_wdata,
  input logic [REG_W-1:0]      reg_rdata,
  input logic [NUM_SGI-1:0]    sgi_set,
  input logic                  ack_valid,
  input logic [NUM_IRQ-1:0]    enable_eff,
  input logic [NUM_IRQ-1:0]    pend_eff,
  input logic [NUM_IRQ-HW_BASE-1:0] rise_hit
);
  localparam int LAST_W = NUM_IRQ / REG_W - 1;
  logic [RGN_W-1:0]  c_rgn;
  logic [WIDX_W-1:0] c_widx;
  assign c_rgn  = reg_addr[ADDR_W-1:7];
  assign c_widx = reg_addr[6:2];

  AST_SET_EN_ZERO_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && c_rgn == RGN_SET_EN && reg_wdata == '0 |=> $stable(enable_eff)); // R1

  AST_CLR_EN_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && c_rgn == RGN_CLR_EN && c_widx == WIDX_W'(LAST_W) && (&reg_wdata)
    |=> enable_eff[NUM_IRQ-1 -: REG_W] == '0); // R1

  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rgn == RGN_SET_EN || c_rgn == RGN_SET_PD) && c_widx == '0
    |-> reg_rdata[PRIV_BASE-1:NUM_SGI] == '0); // R2

  AST_SGI_WRITE_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && c_rgn == RGN_CLR_PD && !ack_valid
    |=> (pend_eff[NUM_SGI-1:0] & $past(pend_eff[NUM_SGI-1:0])) == $past(pend_eff[NUM_SGI-1:0])); // R3

  for (genvar k = 0; k < NUM_SGI; k++) begin : g_sgi
    AST_SGI_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      sgi_set[k] |=> pend_eff[k]); // R4
  end

  for (genvar j = 0; j < NUM_IRQ - HW_BASE; j++) begin : g_edge
    AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_hit[j] |=> pend_eff[HW_BASE+j]); // R6
  end

  AST_TYPE_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    c_rgn == RGN_CTRL && c_widx == 5'd1 |-> reg_rdata == f_type_word(NUM_IRQ)); // R10
endmodule

bind irq_bank irq_bank_chk #(
  .NUM_IRQ   (NUM_IRQ),
  .NUM_SGI   (NUM_SGI),
  .PRIV_BASE (HW_BASE - NUM_PRIV),
  .HW_BASE   (HW_BASE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_addr   (reg_addr),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .sgi_set    (sgi_set),
  .ack_valid  (ack_valid),
  .enable_eff (enable_eff),
  .pend_eff   (pend_eff),
  .rise_hit   (rise_hit)
);

// File: tb/irq_bank_test.sv
module irq_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:2] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] hw_irq = '0;
  logic [15:0] sgi_set = '0;
  logic        ack_valid = 1'b0;
  logic [5:0]  ack_id = '0;
  logic [63:0] irq_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_bank uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_irq(hw_irq),
    .sgi_set(sgi_set), .ack_valid(ack_valid), .ack_id(ack_id), .irq_out(irq_out)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;   // write data, or expected read value
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h000, 32'h0000_0000, 4'd10}, // R10 control reset
    '{1'b0, 12'h004, 32'h0000_0001, 4'd10}, // R10 type word
    '{1'b0, 12'h100, 32'h0000_FFFF, 4'd2},  // R2 fixed enables
    '{1'b0, 12'h104, 32'h0000_0000, 4'd1},  // R1 reset enables
    '{1'b0, 12'hC08, 32'h0000_0000, 4'd9},  // R9 config reset
    '{1'b1, 12'h100, 32'hFFFF_FFFF, 4'd1},
    '{1'b0, 12'h100, 32'hE000_FFFF, 4'd2},  // R2 ids 16-28 stay 0
    '{1'b0, 12'h180, 32'hE000_FFFF, 4'd1},  // R1 clear view same
    '{1'b1, 12'h100, 32'h0000_0000, 4'd1},
    '{1'b0, 12'h100, 32'hE000_FFFF, 4'd1},  // R1 zero write no effect
    '{1'b1, 12'h180, 32'hFFFF_FFFF, 4'd2},
    '{1'b0, 12'h100, 32'h0000_FFFF, 4'd2},  // R2 sgi enables cannot clear
    '{1'b1, 12'h104, 32'h0000_F00F, 4'd1},
    '{1'b0, 12'h184, 32'h0000_F00F, 4'd1},  // R1
    '{1'b1, 12'h184, 32'h0000_0003, 4'd1},
    '{1'b0, 12'h104, 32'h0000_F00C, 4'd1},  // R1 clear
    '{1'b1, 12'h200, 32'hFFFF_FFFF, 4'd3},
    '{1'b0, 12'h280, 32'hE000_0000, 4'd3},  // R3 sgi/reserved protected
    '{1'b1, 12'h280, 32'h4000_0000, 4'd3},
    '{1'b0, 12'h200, 32'hA000_0000, 4'd3},  // R3 clear pending
    '{1'b1, 12'h204, 32'h0000_0300, 4'd3},
    '{1'b1, 12'h284, 32'h0000_0100, 4'd3},
    '{1'b0, 12'h204, 32'h0000_0200, 4'd3},  // R3
    '{1'b1, 12'hC00, 32'hFFFF_FFFF, 4'd9},
    '{1'b0, 12'hC00, 32'h5555_5555, 4'd9},  // R9 model bits only
    '{1'b1, 12'hC04, 32'hFFFF_FFFF, 4'd9},
    '{1'b0, 12'hC04, 32'h0000_0000, 4'd9},  // R9 read-only word
    '{1'b1, 12'hC0C, 32'h1234_5678, 4'd9},
    '{1'b0, 12'hC0C, 32'h1234_5678, 4'd9},  // R9 full word
    '{1'b1, 12'h000, 32'hFFFF_FFFF, 4'd10},
    '{1'b0, 12'h000, 32'h0000_0001, 4'd10}  // R10 control bit 0 only
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a[11:2]; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] e);
    reg_addr = a[11:2];
    #1;
    chk(tag, {32'd0, reg_rdata}, {32'd0, e});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    hw_irq = '0; sgi_set = '0; ack_valid = 1'b0; reg_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ack(input logic [5:0] id);
    @(negedge clk);
    ack_valid = 1'b1; ack_id = id;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    chk("R8 reset irq_out", irq_out, 64'd0);
    for (int v = 0; v < NV; v++) begin
      if (VECS[v].wr) bus_wr(VECS[v].addr, VECS[v].data);
      else rd_chk($sformatf("R%0d table %0d", VECS[v].req, v), VECS[v].addr, VECS[v].data);
    end
    rd_chk("R10 unmapped", 12'h300, 32'd0);
    bus_wr(12'h004, 32'hFFFF_FFFF);
    rd_chk("R10 type ignores write", 12'h004, 32'h0000_0001);

    // R4 and R8: software trigger with global gate
    do_reset();
    @(negedge clk); sgi_set = 16'h0008;
    @(negedge clk); sgi_set = '0;
    rd_chk("R4 sgi pending", 12'h200, 32'h0000_0008);
    chk("R8 gate off", irq_out, 64'd0);
    bus_wr(12'h000, 32'h1);
    #1 chk("R8 gate on", irq_out, 64'h8);
    bus_wr(12'h280, 32'h0000_0008);
    rd_chk("R3 sgi clear ignored", 12'h280, 32'h0000_0008);
    ack(6'd3);
    #1 chk("R5 ack clears sgi", irq_out, 64'd0);

    // R6 edge source id 40
    bus_wr(12'hC08, 32'h0002_0000);
    bus_wr(12'h104, 32'h0000_0300);
    hw_irq[8] = 1'b1;
    @(negedge clk);
    rd_chk("R6 not yet pending", 12'h204, 32'h0);
    @(negedge clk);
    rd_chk("R6 edge pending", 12'h204, 32'h0000_0100);
    hw_irq[8] = 1'b0;
    repeat (3) @(negedge clk);
    rd_chk("R6 edge held", 12'h204, 32'h0000_0100);
    #1 chk("R8 edge out", irq_out, 64'h0000_0100_0000_0000);
    ack(6'd40);
    rd_chk("R5 ack clears edge", 12'h204, 32'h0);

    // R7 level source id 41
    hw_irq[9] = 1'b1;
    @(negedge clk);
    rd_chk("R7 level follows high", 12'h204, 32'h0000_0200);
    ack(6'd41);
    rd_chk("R5 level stays while high", 12'h204, 32'h0000_0200);
    hw_irq[9] = 1'b0;
    @(negedge clk);
    rd_chk("R7 level drops", 12'h204, 32'h0);
    bus_wr(12'h204, 32'h0000_0200);
    @(negedge clk);
    rd_chk("R7 software set holds", 12'h284, 32'h0000_0200);
    #1 chk("R8 level out", irq_out, 64'h0000_0200_0000_0000);
    bus_wr(12'h000, 32'h0);
    #1 chk("R8 gate cleared", irq_out, 64'd0);

    finish_run();
  end
endmodule